// File: doc/BRIEF.md
# I2C Register Target with Windowed Sessions

This block is an I2C target that gives a bus master byte-wide access to a register space through a 16-bit register pointer. It filters the bus on its 7-bit device address. It accepts writes that first set the pointer and then carry data bytes. It serves random reads, where a pointer-setting write is followed by a repeated START, and current-address reads that use the present pointer. The register file sits outside the block, behind a simple strobe port with a one-cycle read latency.

Access is tied to a communication window that the surrounding system grants through `win_open`. When the window opens, the pointer is reloaded from `default_ptr`. If the master addresses the block while the window is closed, the block holds SCL low until the window is granted. While `low_power` is high, the block refuses its address and asks for a wake-up. A STOP on its own does not end the session. A one-byte write to the end address followed by a STOP produces a `win_end` pulse, and the system uses that pulse to close the window.

The control is one state machine. ST_IDLE waits for a START. ST_RX shifts in a byte. The byte is, in turn, the device address, the pointer high byte, the pointer low byte, and then data. ST_STRETCH holds SCL low. ST_ACK drives the acknowledge bit. ST_TX shifts out a read byte. ST_MACK samples the master's acknowledge. ST_RDWAIT holds a fetched byte until the clock falls.

The transitions are as follows:
- START from any state goes to ST_RX with the address field selected.
- STOP from any state goes to ST_IDLE.
- ST_RX goes to ST_ACK after a full byte.
- For an address byte, ST_RX goes instead to ST_IDLE on a mismatch or in low power, and to ST_STRETCH when the window is closed.
- ST_STRETCH goes to ST_ACK once the window is granted.
- ST_ACK goes to ST_TX in read mode and to ST_RX otherwise.
- ST_TX goes to ST_MACK after eight bits.
- ST_MACK goes to ST_RDWAIT on an acknowledge and to ST_IDLE on a not-acknowledge.
- ST_RDWAIT goes to ST_TX.

Top module: `i2c_win_target`

## Requirements
- R1: After reset the block drives neither SCL nor SDA low, and `win_end` and `wake_req` are low.
- R2: Only an address byte whose upper seven bits equal DEV_ADDR (default 7'b1110100, so 0xE8 writes and 0xE9 reads, bit 0 being the read flag) is acknowledged. Any other address is not acknowledged, and the bytes that follow it are ignored until the next START.
- R3: After a write address byte, the first byte sets pointer bits [15:8] and the second sets bits [7:0]. Every further byte is acknowledged and issued as one `rf_wr_en` strobe with `rf_addr` equal to the pointer. `rf_wr_en` and `rf_rd_en` are never high together.
- R4: After a read address byte, the block returns the register at the pointer, most significant bit first. This includes a read that follows a pointer-setting write and a repeated START.
- R5: A rising edge of `win_open` loads the pointer from `default_ptr`. A current-address read with no address phase then starts at that value.
- R6: The pointer advances by one for each byte written or fetched, and wraps from 0xFFFF to 0x0000.
- R7: A STOP on its own gives no `win_end` pulse. A STOP that follows a data byte written to END_ADDR (default 0xEEEE) gives a `win_end` pulse exactly one cycle long.
- R8: A matching address received while the window is closed makes the block hold SCL low. The block holds it only while the window is closed and releases it with the acknowledge once the window is granted, and the transaction then completes normally.
- R9: A matching address received while `low_power` is high is not acknowledged, and `wake_req` pulses for one cycle. A retry after `low_power` falls is acknowledged.
- R10: After the master does not acknowledge a read byte, the block leaves SDA undriven and fetches no further register until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| scl_oe | output | 1 | High to pull SCL low (stretch) |
| sda_oe | output | 1 | High to pull SDA low |
| win_open | input | 1 | Communication window granted |
| low_power | input | 1 | Device is in its low-power state |
| default_ptr | input | 16 | Pointer value loaded when the window opens |
| wake_req | output | 1 | One-cycle wake-up request |
| win_end | output | 1 | One-cycle end-of-window pulse |
| rf_addr | output | 16 | Register file address (current pointer) |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wdata | output | 8 | Register write data |
| rf_rd_en | output | 1 | Register read strobe |
| rf_rdata | input | 8 | Read data, valid the cycle after `rf_rd_en` |

## Verification
Every bus event reaches the control logic three clock cycles after the pad changes: two synchroniser flops and one edge-detect flop. Acknowledge and data bits therefore change a few cycles after the master's SCL fall. The bench samples SDA in the middle of the SCL high phase, ten cycles after the line rises, and sets its own SDA ten cycles into the low phase. Register strobes and the `win_end` and `wake_req` pulses are counted by monitors on every clock edge. Each count is compared only after the whole bus phase that causes it, so the exact cycle of a strobe never decides a check. The stretch check waits forty cycles with SCL released before it expects the line still low.

// File: rtl/i2c_win_pkg.sv
package i2c_win_pkg;
    localparam int PTR_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_STRETCH,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_RDWAIT
    } st_t;

    typedef enum logic [1:0] {
        FLD_DEV,
        FLD_PHI,
        FLD_PLO,
        FLD_DATA
    } fld_t;
endpackage

// File: rtl/i2c_win_sync.sv
module i2c_win_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= '1;
                    else        stage[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= '1;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/i2c_win_cond.sv
module i2c_win_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic bus_start,
    output logic bus_stop,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign bus_start = scl_s && scl_p && sda_p && !sda_s;
    assign bus_stop  = scl_s && scl_p && !sda_p && sda_s;
    assign scl_rise  = scl_s && !scl_p;
    assign scl_fall  = !scl_s && scl_p;
endmodule

// File: rtl/i2c_win_ptr.sv
module i2c_win_ptr
    import i2c_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_open,
    input  logic [PTR_W-1:0]  default_ptr,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              step,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [PTR_W-1:0]  ptr,
    output logic              win_held
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr      <= '0;
            win_held <= 1'b0;
        end else begin
            win_held <= win_open;
            if (win_open && !win_held)
                ptr <= default_ptr;
            else if (ld_hi)
                ptr[PTR_W-1 -: BYTE_W] <= byte_in;
            else if (ld_lo)
                ptr[BYTE_W-1:0] <= byte_in;
            else if (step)
                ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_win_fsm.sv
module i2c_win_fsm
    import i2c_win_pkg::*;
#(
    parameter logic [6:0]       DEV_ADDR = 7'b1110100,
    parameter logic [PTR_W-1:0] END_ADDR = 16'hEEEE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              win_ok,
    input  logic              low_power,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [BYTE_W-1:0] rf_rdata,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              rf_wr_en,
    output logic              rf_rd_en,
    output logic [BYTE_W-1:0] rf_wdata,
    output logic              ptr_ld_hi,
    output logic              ptr_ld_lo,
    output logic              ptr_step,
    output logic              win_end,
    output logic              wake_req
);
    localparam logic [3:0] BITS_DONE = 4'(BYTE_W);
    localparam logic [3:0] TX_LAST   = 4'(BYTE_W - 1);

    st_t               state, st_n;
    fld_t              fld;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rd_mode;
    logic              end_armed;
    logic              ld_pend;
    logic              byte_done;
    logic              wake_set;
    logic              rd_go;
    logic              wr_go;

    assign byte_done = (state == ST_RX) && scl_fall && (cnt == BITS_DONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_n;
    end

    // next state and strobes
    always_comb begin
        st_n      = state;
        wake_set  = 1'b0;
        rd_go     = 1'b0;
        wr_go     = 1'b0;
        ptr_ld_hi = 1'b0;
        ptr_ld_lo = 1'b0;
        if (bus_start) begin
            st_n = ST_RX;
        end else if (bus_stop) begin
            st_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: st_n = ST_IDLE;
                ST_RX: begin
                    if (byte_done) begin
                        unique case (fld)
                            FLD_DEV: begin
                                if (rx_sh[7:1] != DEV_ADDR) begin
                                    st_n = ST_IDLE;
                                end else if (low_power) begin
                                    st_n     = ST_IDLE;
                                    wake_set = 1'b1;
                                end else if (!win_ok) begin
                                    st_n = ST_STRETCH;
                                end else begin
                                    st_n  = ST_ACK;
                                    rd_go = rx_sh[0];
                                end
                            end
                            FLD_PHI: begin
                                st_n      = ST_ACK;
                                ptr_ld_hi = 1'b1;
                            end
                            FLD_PLO: begin
                                st_n      = ST_ACK;
                                ptr_ld_lo = 1'b1;
                            end
                            FLD_DATA: begin
                                st_n  = ST_ACK;
                                wr_go = 1'b1;
                            end
                        endcase
                    end
                end
                ST_STRETCH: begin
                    if (win_ok) begin
                        st_n  = ST_ACK;
                        rd_go = rx_sh[0];
                    end
                end
                ST_ACK: begin
                    if (scl_fall) st_n = rd_mode ? ST_TX : ST_RX;
                end
                ST_TX: begin
                    if (scl_fall && cnt == TX_LAST) st_n = ST_MACK;
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            st_n = ST_IDLE;
                        end else begin
                            st_n  = ST_RDWAIT;
                            rd_go = 1'b1;
                        end
                    end
                end
                ST_RDWAIT: begin
                    if (scl_fall) st_n = ST_TX;
                end
            endcase
        end
    end

    // line drivers and register port
    always_comb begin
        scl_oe   = (state == ST_STRETCH);
        sda_oe   = (state == ST_ACK) || (state == ST_STRETCH) ||
                   ((state == ST_TX) && !tx_sh[BYTE_W-1]);
        rf_wr_en = wr_go;
        rf_rd_en = rd_go;
        rf_wdata = rx_sh;
        ptr_step = wr_go || rd_go;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld       <= FLD_DEV;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '1;
            rd_mode   <= 1'b0;
            end_armed <= 1'b0;
            ld_pend   <= 1'b0;
            win_end   <= 1'b0;
            wake_req  <= 1'b0;
        end else begin
            ld_pend  <= rd_go;
            wake_req <= wake_set;
            win_end  <= bus_stop && end_armed;
            if (ld_pend) tx_sh <= rf_rdata;
            if (bus_start) begin
                fld       <= FLD_DEV;
                cnt       <= '0;
                rd_mode   <= 1'b0;
                end_armed <= 1'b0;
            end else if (bus_stop) begin
                end_armed <= 1'b0;
                cnt       <= '0;
            end else begin
                if (state == ST_RX && scl_rise && cnt != BITS_DONE) begin
                    rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                    cnt   <= cnt + 1'b1;
                end
                if (byte_done) begin
                    cnt <= '0;
                    unique case (fld)
                        FLD_DEV: begin
                            fld     <= FLD_PHI;
                            rd_mode <= rx_sh[0];
                        end
                        FLD_PHI: fld <= FLD_PLO;
                        FLD_PLO: fld <= FLD_DATA;
                        FLD_DATA: end_armed <= (ptr == END_ADDR);
                    endcase
                end
                if (state == ST_ACK && scl_fall) cnt <= '0;
                if (state == ST_RDWAIT && scl_fall) cnt <= '0;
                if (state == ST_TX && scl_fall) begin
                    cnt   <= cnt + 1'b1;
                    tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
                end
            end
        end
    end
endmodule

// File: rtl/i2c_win_target.sv
module i2c_win_target
    import i2c_win_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'b1110100,
    parameter logic [15:0] END_ADDR    = 16'hEEEE,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        win_open,
    input  logic        low_power,
    input  logic [15:0] default_ptr,
    output logic        wake_req,
    output logic        win_end,
    output logic [15:0] rf_addr,
    output logic        rf_wr_en,
    output logic [7:0]  rf_wdata,
    output logic        rf_rd_en,
    input  logic [7:0]  rf_rdata
);
    logic [1:0]       line_s;
    logic             bus_start, bus_stop, scl_rise, scl_fall;
    logic             ptr_ld_hi, ptr_ld_lo, ptr_step, win_held;
    logic [PTR_W-1:0] ptr;

    i2c_win_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (line_s)
    );

    i2c_win_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (line_s[1]),
        .sda_s     (line_s[0]),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    i2c_win_ptr u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_open    (win_open),
        .default_ptr (default_ptr),
        .ld_hi       (ptr_ld_hi),
        .ld_lo       (ptr_ld_lo),
        .step        (ptr_step),
        .byte_in     (rf_wdata),
        .ptr         (ptr),
        .win_held    (win_held)
    );

    i2c_win_fsm #(.DEV_ADDR(DEV_ADDR), .END_ADDR(END_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (line_s[0]),
        .win_ok    (win_open && win_held),
        .low_power (low_power),
        .ptr       (ptr),
        .rf_rdata  (rf_rdata),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .rf_wr_en  (rf_wr_en),
        .rf_rd_en  (rf_rd_en),
        .rf_wdata  (rf_wdata),
        .ptr_ld_hi (ptr_ld_hi),
        .ptr_ld_lo (ptr_ld_lo),
        .ptr_step  (ptr_step),
        .win_end   (win_end),
        .wake_req  (wake_req)
    );

    assign rf_addr = ptr;
endmodule

// File: rtl/i2c_win_chk.sv
module i2c_win_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic win_open,
    input logic low_power,
    input logic wake_req,
    input logic win_end,
    input logic rf_wr_en,
    input logic rf_rd_en
);
    AST_NO_DUAL_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_wr_en && rf_rd_en)); // R3
    AST_END_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> !win_end); // R7
    AST_STRETCH_ONLY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> !$past(win_open)); // R8
    AST_STRETCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && win_open && $past(win_open)) |=> !scl_oe); // R8
    AST_WAKE_FROM_LOW_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(low_power)); // R9
    AST_WAKE_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req); // R9
endmodule

bind i2c_win_target i2c_win_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_oe    (scl_oe),
    .win_open  (win_open),
    .low_power (low_power),
    .wake_req  (wake_req),
    .win_end   (win_end),
    .rf_wr_en  (rf_wr_en),
    .rf_rd_en  (rf_rd_en)
);

// File: tb/i2c_win_target_bench.sv
module i2c_win_target_bench;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        win_open = 1'b1;
    logic        low_power = 1'b0;
    logic [15:0] default_ptr = 16'h0100;
    logic        scl_oe, sda_oe, wake_req, win_end, rf_wr_en, rf_rd_en;
    logic [15:0] rf_addr;
    logic [7:0]  rf_wdata;
    logic [7:0]  rf_rdata = 8'h00;
    logic        scl_bus, sda_bus;

    always #4 clk = ~clk;

    assign scl_bus = scl_m & ~scl_oe;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_win_target u_i2c_win_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .win_open(win_open),
        .low_power(low_power), .default_ptr(default_ptr),
        .wake_req(wake_req), .win_end(win_end), .rf_addr(rf_addr),
        .rf_wr_en(rf_wr_en), .rf_wdata(rf_wdata), .rf_rd_en(rf_rd_en),
        .rf_rdata(rf_rdata)
    );

    function automatic logic [7:0] rd_fn(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    // register file model and monitors
    logic [15:0] wlog_a [32];
    logic [7:0]  wlog_d [32];
    int wcnt = 0, rcnt = 0, end_cnt = 0, wake_cnt = 0;
    always @(posedge clk) begin
        if (rf_rd_en) begin
            rf_rdata <= rd_fn(rf_addr);
            rcnt <= rcnt + 1;
        end
        if (rf_wr_en) begin
            wlog_a[wcnt % 32] <= rf_addr;
            wlog_d[wcnt % 32] <= rf_wdata;
            wcnt <= wcnt + 1;
        end
        if (win_end)  end_cnt  <= end_cnt + 1;
        if (wake_req) wake_cnt <= wake_cnt + 1;
    end

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_hi();
        scl_m = 1'b1;
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wq(Q);
        scl_hi(); wq(2*Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wq(Q);
        scl_hi(); wq(Q);
        b = sda_bus; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(Q);
        scl_hi(); wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(Q);
        scl_hi(); wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        logic x;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(x);
        ack = !x;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] v);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            bit_in(x);
            v[i] = x;
        end
        bit_out(!mack);
    endtask

    task automatic do_write(input logic [15:0] a, input int n, input logic [7:0] base,
                            input string req);
        bit ack;
        int w0;
        w0 = wcnt;
        i2c_start();
        send_byte(8'hE8, ack); chk(ack, "R2", "write address ack", ack, 1);
        send_byte(a[15:8], ack);
        send_byte(a[7:0], ack);
        for (int i = 0; i < n; i++) begin
            send_byte(base + 8'(i * 3), ack);
            chk(ack, "R3", "data byte ack", ack, 1);
        end
        i2c_stop();
        wq(4);
        chk(wcnt - w0 == n, "R3", "write strobe count", wcnt - w0, n);
        for (int i = 0; i < n; i++) begin
            chk(wlog_a[(w0 + i) % 32] == a + 16'(i), req, "write address",
                wlog_a[(w0 + i) % 32], a + 16'(i));
            chk(wlog_d[(w0 + i) % 32] == base + 8'(i * 3), "R3", "write data",
                wlog_d[(w0 + i) % 32], base + 8'(i * 3));
        end
    endtask

    task automatic do_read(input bit set_addr, input logic [15:0] a,
                           input logic [15:0] exp_a, input int n, input string req);
        bit ack;
        logic [7:0] v;
        if (set_addr) begin
            i2c_start();
            send_byte(8'hE8, ack);
            send_byte(a[15:8], ack);
            send_byte(a[7:0], ack);
        end
        i2c_start();
        send_byte(8'hE9, ack); chk(ack, "R2", "read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            chk(v == rd_fn(exp_a + 16'(i)), req, "read data", v, rd_fn(exp_a + 16'(i)));
        end
        i2c_stop();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        bit ack;
        logic x;
        int c0;
        void'($urandom(32'd4242));
        wq(5);
        rst_n = 1'b1;
        wq(5);
        // R1 reset state
        chk(!scl_oe && !sda_oe, "R1", "lines released", {scl_oe, sda_oe}, 0);
        chk(!win_end && !wake_req, "R1", "pulses low", {win_end, wake_req}, 0);

        // R2 foreign address ignored
        c0 = wcnt;
        i2c_start();
        send_byte(8'hD0, ack); chk(!ack, "R2", "foreign address nack", ack, 0);
        send_byte(8'h00, ack); send_byte(8'h10, ack); send_byte(8'h77, ack);
        chk(!ack, "R2", "data after foreign address", ack, 0);
        i2c_stop(); wq(4);
        chk(wcnt == c0, "R2", "no write after foreign address", wcnt - c0, 0);

        // R3 / R6 writes
        do_write(16'h1234, 3, 8'h40, "R6");
        chk(end_cnt == 0, "R7", "plain stop no end pulse", end_cnt, 0);
        do_write(16'hFFFF, 2, 8'h11, "R6");   // R6 wrap to 0x0000

        // R4 random read, R6 increment
        do_read(1'b1, 16'h2F80, 16'h2F80, 4, "R4");
        // R5 window reopen loads default pointer
        win_open = 1'b0; default_ptr = 16'h0A5C; wq(5);
        win_open = 1'b1; wq(5);
        do_read(1'b0, 16'h0, 16'h0A5C, 2, "R5");
        do_read(1'b0, 16'h0, 16'h0A5E, 2, "R6");

        // R7 end-of-window write
        c0 = end_cnt;
        do_write(16'hEEEE, 1, 8'h00, "R7");
        chk(end_cnt - c0 == 1, "R7", "end pulse count", end_cnt - c0, 1);

        // R8 stretch while window closed
        win_open = 1'b0; wq(5);
        i2c_start();
        for (int i = 7; i >= 0; i--) bit_out(8'hE8 >> i);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(40);
        chk(scl_bus == 1'b0, "R8", "scl held low", scl_bus, 0);
        default_ptr = 16'h0300;
        win_open = 1'b1;
        while (!scl_bus) @(negedge clk);
        wq(Q);
        x = sda_bus;
        wq(Q); scl_m = 1'b0; wq(Q);
        chk(x == 1'b0, "R8", "ack after grant", x, 0);
        c0 = wcnt;
        send_byte(8'h05, ack); send_byte(8'h06, ack); send_byte(8'h99, ack);
        i2c_stop(); wq(4);
        chk(wcnt - c0 == 1 && wlog_a[c0 % 32] == 16'h0506, "R8", "stretched write lands",
            wlog_a[c0 % 32], 16'h0506);

        // R9 low power
        low_power = 1'b1;
        c0 = wake_cnt;
        i2c_start();
        send_byte(8'hE8, ack); chk(!ack, "R9", "low power nack", ack, 0);
        i2c_stop(); wq(4);
        chk(wake_cnt - c0 == 1, "R9", "wake request", wake_cnt - c0, 1);
        low_power = 1'b0; wq(200);
        i2c_start();
        send_byte(8'hE8, ack); chk(ack, "R9", "retry ack", ack, 1);
        i2c_stop();

        // R10 master nack releases SDA
        i2c_start();
        send_byte(8'hE8, ack); send_byte(8'h40, ack); send_byte(8'h00, ack);
        i2c_start();
        send_byte(8'hE9, ack);
        c0 = rcnt;
        recv_byte(1'b0, rf_wdata_dummy);
        for (int i = 0; i < 9; i++) begin
            bit_in(x);
            chk(x == 1'b1, "R10", "sda released after nack", x, 1);
        end
        chk(rcnt == c0, "R10", "no fetch after nack", rcnt - c0, 0);
        i2c_stop();

        // constrained random mix
        for (int t = 0; t < 14; t++) begin
            logic [15:0] a;
            int n;
            a = 16'($urandom);
            if (a >= 16'hEE00 && a <= 16'hEEFF) a = 16'h5000;
            n = 1 + int'($urandom % 3);
            if ($urandom % 2 == 0) do_write(a, n, 8'($urandom), "R3");
            else                   do_read(1'b1, a, a, n, "R4");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic [7:0] rf_wdata_dummy;
endmodule